// File: doc/BRIEF.md
# PS/2 Host Register Interface

This block gives a processor a small register window onto one PS/2 keyboard or mouse. On one side it has a single-cycle synchronous register bus. On the other side it has a byte-level device port. Received bytes arrive with a valid/ready handshake. Transmitted bytes leave as a one-cycle strobe with a data byte. The line-level PS/2 clocking is handled elsewhere.

Software uses five word registers:
- **Control** holds the interrupt-enable bit and the force-interrupt bit.
- **Status** reports whether a received byte is waiting.
- **Data** pops a waiting byte, or repeats the last one taken if nothing is waiting.
- **Clock divisor** is plain storage.
- **Interrupt identification** reports the pending flag.

The last 32 bytes of the aperture form an identification window that reads as zero.

The single interrupt output is registered. It rises when a byte is waiting and receive interrupts are enabled. It also rises whenever the force bit is set, with or without data.

Top module: `ps2_host_regs`

## Requirements
- R1: After reset, control, divisor, the last-byte latch and the read-data register are all zero, and irq, rx_ready and tx_valid are low.
- R2: Control (byte offset 0x00) and clock divisor (0x0C) store the low CTRL_W and DIV_W bits of a write and read them back zero-extended.
- R3: Status (0x04) reads 0x10 while rx_valid is high, and 0 otherwise.
- R4: Interrupt identification (0x10) reads bit 1 as 1 and bit 0 as the current rx_valid. All other bits read 0.
- R5: A data read (0x08) while rx_valid is high raises rx_ready in that same cycle and returns rx_data. It also stores rx_data as the last byte.
- R6: A data read while rx_valid is low leaves rx_ready low and returns the last stored byte.
- R7: A write to data makes tx_valid high for exactly the following cycle, with tx_data equal to the low byte written.
- R8: irq is high one cycle after the cycle in which control bit 3 is set, or in which control bit 4 and rx_valid are both set. Otherwise irq is low.
- R9: A control write takes effect on irq at the same clock edge that updates the control register, using the rx_valid level present at that edge.
- R10: Reads in the identification window 0xFE0 to 0xFFC return 0 and never raise rx_ready.
- R11: Writes to offsets other than control, data and divisor change no register and raise no tx_valid. Reads of those offsets return 0.
- R12: bus_rdata is registered. It changes only in the cycle after a read and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the aperture |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| rx_valid | input | 1 | Device has a received byte waiting |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Byte taken this cycle |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case is a data read with nothing pending. It must return the byte consumed by an earlier read, so the bench first pops one value and then drops rx_valid. After that it changes rx_data to a different value and reads again, so that a repeated byte cannot be confused with a pass-through of the idle bus. The forced interrupt is tested in the same way. rx_valid is toggled while bit 3 stays set and bit 4 is clear, which shows that irq does not follow the pending flag in that mode.

// File: rtl/ps2h_pkg.sv
package ps2h_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL,
    SEL_STAT,
    SEL_DATA,
    SEL_DIV,
    SEL_IID,
    SEL_IDWIN,
    SEL_NONE
  } reg_sel_e;

  localparam logic [31:0] STAT_PENDING = 32'h0000_0010;
  localparam int unsigned FORCE_BIT = 3;
  localparam int unsigned RXIE_BIT  = 4;
endpackage

// File: rtl/ps2h_decode.sv
module ps2h_decode
  import ps2h_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              in_idwin;

  assign word     = addr[ADDR_W-1:2];
  assign in_idwin = &addr[ADDR_W-1:5];

  always_comb begin
    if (in_idwin) begin
      sel = SEL_IDWIN;
    end else begin
      case (word)
        WORD_W'(0): sel = SEL_CTRL;
        WORD_W'(1): sel = SEL_STAT;
        WORD_W'(2): sel = SEL_DATA;
        WORD_W'(3): sel = SEL_DIV;
        WORD_W'(4): sel = SEL_IID;
        default:    sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ps2h_regfile.sv
module ps2h_regfile
  import ps2h_pkg::*;
#(
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [31:0]       wdata,
  output logic [CTRL_W-1:0] ctrl_d,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              tx_valid,
  output logic [7:0]        tx_data
);
  logic              ctrl_en, div_en, tx_fire;
  logic [DIV_W-1:0]  div_d;
  logic [7:0]        txd_d;

  assign ctrl_en = wr_en && (sel == SEL_CTRL);
  assign div_en  = wr_en && (sel == SEL_DIV);
  assign tx_fire = wr_en && (sel == SEL_DATA);

  always_comb begin
    ctrl_d = ctrl_en ? wdata[CTRL_W-1:0] : ctrl_q;
    div_d  = div_en  ? wdata[DIV_W-1:0]  : div_q;
    txd_d  = tx_fire ? wdata[7:0]        : tx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      div_q    <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      div_q    <= div_d;
      tx_valid <= tx_fire;
      tx_data  <= txd_d;
    end
  end
endmodule

// File: rtl/ps2h_rx_path.sv
module ps2h_rx_path
  import ps2h_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  reg_sel_e   sel,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       rx_ready,
  output logic [7:0] rd_byte
);
  logic [7:0] last_q, last_d;

  assign rx_ready = rd_en && (sel == SEL_DATA) && rx_valid;

  always_comb begin
    last_d  = rx_ready ? rx_data : last_q;
    rd_byte = last_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= last_d;
  end
endmodule

// File: rtl/ps2h_irq.sv
module ps2h_irq
  import ps2h_pkg::*;
#(
  parameter int unsigned CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_d,
  input  logic              pending,
  output logic              irq
);
  logic irq_d;

  assign irq_d = ctrl_d[FORCE_BIT] | (ctrl_d[RXIE_BIT] & pending);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/ps2_host_regs.sv
module ps2_host_regs
  import ps2h_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              irq
);
  reg_sel_e          sel;
  logic              wr_en, rd_en;
  logic [CTRL_W-1:0] ctrl_d, ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [7:0]        rd_byte;
  logic [31:0]       rdata_d;

  assign wr_en = bus_en &  bus_wr;
  assign rd_en = bus_en & ~bus_wr;

  ps2h_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .sel(sel));

  ps2h_regfile #(.CTRL_W(CTRL_W), .DIV_W(DIV_W)) u_regs (
    .clk, .rst_n, .wr_en, .sel, .wdata(bus_wdata),
    .ctrl_d, .ctrl_q, .div_q, .tx_valid, .tx_data
  );

  ps2h_rx_path u_rx (
    .clk, .rst_n, .rd_en, .sel, .rx_valid, .rx_data, .rx_ready, .rd_byte
  );

  ps2h_irq #(.CTRL_W(CTRL_W)) u_irq (
    .clk, .rst_n, .ctrl_d, .pending(rx_valid), .irq
  );

  always_comb begin
    rdata_d = bus_rdata;
    if (rd_en) begin
      case (sel)
        SEL_CTRL: rdata_d = 32'(ctrl_q);
        SEL_STAT: rdata_d = rx_valid ? STAT_PENDING : 32'd0;
        SEL_DATA: rdata_d = 32'(rd_byte);
        SEL_DIV:  rdata_d = 32'(div_q);
        SEL_IID:  rdata_d = {30'd0, 1'b1, rx_valid};
        default:  rdata_d = 32'd0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rdata_d;
  end
endmodule

// File: rtl/ps2h_chk.sv
module ps2h_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CTRL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              rx_valid,
  input logic [7:0]        rx_data,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic [7:0]        tx_data,
  input logic              irq,
  input logic [CTRL_W-1:0] ctrl_q
);
  logic data_rd, data_wr, stat_rd;
  assign data_rd = bus_en && !bus_wr && (bus_addr == ADDR_W'(8));
  assign data_wr = bus_en &&  bus_wr && (bus_addr == ADDR_W'(8));
  assign stat_rd = bus_en && !bus_wr && (bus_addr == ADDR_W'(4));

  // R5
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (rx_valid && data_rd));

  // R5
  pop_returns_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && rx_valid) |=> (bus_rdata == 32'($past(rx_data))));

  // R3
  status_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (bus_rdata == ($past(rx_valid) ? 32'h10 : 32'h0)));

  // R7
  tx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (tx_valid && tx_data == $past(bus_wdata[7:0])));

  // R7
  tx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> !tx_valid);

  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == (ctrl_q[3] | (ctrl_q[4] & $past(rx_valid)))));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && !bus_wr) |=> $stable(bus_rdata));
endmodule

bind ps2_host_regs ps2h_chk #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_chk (.*);

// File: tb/ps2_host_regs_bench.sv
module ps2_host_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_ready, tx_valid, irq;
  logic [7:0]  tx_data;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ps2_host_regs u_ps2_host_regs (
    .clk, .rst_n, .bus_en, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .rx_valid, .rx_data, .rx_ready, .tx_valid, .tx_data, .irq
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_en = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d, output logic rdy);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 rdy = rx_ready;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic r;
    check("R1 irq", 32'(irq), 0);
    check("R1 tx_valid", 32'(tx_valid), 0);
    check("R1 rdata", bus_rdata, 0);
    rd(12'h000, d, r); check("R1 ctrl", d, 0);
    rd(12'h00C, d, r); check("R1 div", d, 0);
    rd(12'h008, d, r); check("R1 last byte", d, 0);
    check("R1 rx_ready", 32'(r), 0);
  endtask

  task automatic t_readback();
    logic [31:0] d; logic r;
    wr(12'h00C, 32'hABCD_1235); rd(12'h00C, d, r); check("R2 div", d, 32'h35);
    wr(12'h000, 32'hFFFF_FF40); rd(12'h000, d, r); check("R2 ctrl", d, 32'h40);
    wr(12'h000, 32'h0);
  endtask

  task automatic t_status();
    logic [31:0] d; logic r;
    rd(12'h004, d, r); check("R3 idle", d, 0);
    rd(12'h010, d, r); check("R4 idle", d, 32'h2);
    rx_valid = 1'b1; rx_data = 8'h5A;
    rd(12'h004, d, r); check("R3 pending", d, 32'h10);
    rd(12'h010, d, r); check("R4 pending", d, 32'h3);
  endtask

  task automatic t_data();
    logic [31:0] d; logic r;
    rx_valid = 1'b1; rx_data = 8'hC3;
    rd(12'h008, d, r);
    check("R5 ready", 32'(r), 1); check("R5 byte", d, 32'hC3);
    rx_valid = 1'b0; rx_data = 8'h11;
    rd(12'h008, d, r);
    check("R6 ready", 32'(r), 0); check("R6 repeat", d, 32'hC3);
    idle(); check("R12 hold", bus_rdata, 32'hC3);
  endtask

  task automatic t_tx();
    wr(12'h008, 32'h1234_56E7);
    check("R7 strobe", 32'(tx_valid), 1); check("R7 byte", 32'(tx_data), 32'hE7);
    idle(); check("R7 one cycle", 32'(tx_valid), 0);
  endtask

  task automatic t_irq();
    rx_valid = 1'b0;
    wr(12'h000, 32'h08); check("R9 forced now", 32'(irq), 1);
    rx_valid = 1'b1; idle(); idle(); check("R8 forced pend", 32'(irq), 1);
    rx_valid = 1'b0; idle(); idle(); check("R8 forced idle", 32'(irq), 1);
    wr(12'h000, 32'h10); check("R9 enable no data", 32'(irq), 0);
    rx_valid = 1'b1; idle(); check("R8 pend enabled", 32'(irq), 1);
    wr(12'h000, 32'h00); check("R9 disable", 32'(irq), 0);
    rx_valid = 1'b0;
  endtask

  task automatic t_idwin();
    logic [31:0] d; logic r;
    rx_valid = 1'b1; rx_data = 8'h77;
    rd(12'hFE0, d, r); check("R10 low", d, 0); check("R10 no pop", 32'(r), 0);
    rd(12'hFFC, d, r); check("R10 high", d, 0);
    rx_valid = 1'b0;
  endtask

  task automatic t_unmapped();
    logic [31:0] d; logic r;
    wr(12'h000, 32'h05); wr(12'h00C, 32'h09);
    wr(12'h014, 32'hFF); check("R11 no tx", 32'(tx_valid), 0);
    wr(12'h040, 32'hFF);
    rd(12'h000, d, r); check("R11 ctrl kept", d, 32'h05);
    rd(12'h00C, d, r); check("R11 div kept", d, 32'h09);
    rd(12'h018, d, r); check("R11 read zero", d, 0);
  endtask

  initial begin
    rst_n = 1'b0; bus_en = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; rx_valid = 1'b0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_status();
    t_data();
    t_tx();
    t_irq();
    t_idwin();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule